// File: doc/BRIEF.md
# Quad SPI Memory-Emulating Target with Bus Pass-Through

This block lets a host microcontroller that only knows how to talk to serial memory chips exchange bulk data with on-chip logic. To the host it looks like a quad SPI memory. A 24-bit address space maps a RAM data region starting at address zero and a small window of control registers starting at 0xFF0000. Quad I/O read and quad I/O page program move data on all four lanes. A read-status command always reports that no write is in progress, so a host driver that polls before and after programming never waits.

The same host bus is shared with a second, external quad SPI device. A route select input chooses where the host bus goes. When it selects the internal target, the bus is decoded locally and the external device is parked: chip select is held high, the clock is held low and its lanes are not driven. The interrupt from the external device is also masked, so the host does not service it while the bus is taken. When the route selects the external device, clock, chip select and lanes pass straight through in both directions, and the internal target sees an idle bus.

The host bus is sampled by the block's own fast clock through synchronizers, so the host clock must be several times slower than the block clock. Data moves in transactions of up to one 512-byte block, and the address wraps inside the RAM region.

Top module: `qspi_memtarget`

## Requirements
- R1: Opcode 0xEB (quad read): the command byte is taken on io[0], MSB first, on rising host clock edges (mode 0). Six address nibbles follow on io[3:0], most significant nibble first, with io[3] as the nibble MSB. Then come DUMMY_CLKS (default 6) dummy clocks. Data bytes are then driven on io[3:0], high nibble first, each nibble launched after a falling edge so it is valid at the next rising edge.
- R2: Opcode 0x38 (quad page program): command byte and 24-bit quad address as in R1. Data nibbles follow at once, high nibble first, and every completed byte is written at the current address.
- R3: Erase opcodes 0x20, 0xD8 and 0xC7, and any other unknown opcode, write nothing and leave all lanes undriven until chip select rises.
- R4: Address 0xFF0000+k with k < NUM_REGS (default 4) reads and writes 8-bit register k. Any other address at 0xFF0000 or above, and any address at or above RAM_DEPTH (default 1024) below it, reads 0x00 and ignores writes.
- R5: The address advances by one per byte and wraps from RAM_DEPTH-1 to 0, for both reads and writes.
- R6: Opcode 0x05 returns the status byte on io[1] only, MSB first, repeating while chip select stays low. Its bit 0 (write in progress) is always 0. Its upper seven bits are STATUS_ID (default 0x2A, so the byte is 0x54).
- R7: Raising chip select at any point aborts the transaction and releases the lanes. Bytes already completed by a page program stay written. The next select starts again at command decode.
- R8: With route_int low, ext_sck, ext_csn and ext_io_o follow the host pins, host_io_o and host_io_oe follow ext_io_i and ext_io_drv, host_irq follows ext_irq, and the internal target ignores host traffic.
- R9: With route_int high, ext_csn is held high, ext_sck and ext_io_oe are held low, and host_irq is held low whatever ext_irq does.
- R10: A full 512-byte block written by one page program transaction reads back unchanged in one quad read transaction.
- R11: After reset the lanes are undriven and all registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the host bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_int | input | 1 | 1: host bus to internal target; 0: pass-through to external device |
| host_sck | input | 1 | Host serial clock |
| host_csn | input | 1 | Host chip select, active low |
| host_io_i | input | 4 | Host data lanes, host-to-target direction |
| host_io_o | output | 4 | Data lanes returned to the host |
| host_io_oe | output | 4 | Per-lane drive enable toward the host |
| host_irq | output | 1 | Gated external interrupt presented to the host |
| ext_sck | output | 1 | Clock to the external device |
| ext_csn | output | 1 | Chip select to the external device |
| ext_io_o | output | 4 | Data lanes toward the external device |
| ext_io_oe | output | 4 | Per-lane drive enable toward the external device |
| ext_io_i | input | 4 | Data lanes from the external device |
| ext_io_drv | input | 4 | Lanes the external device is currently driving |
| ext_irq | input | 1 | Interrupt from the external device |

## Verification
The assertions assume the host clock holds each phase for more block clock cycles than the synchronizer depth plus two. They also assume route_int changes only while host chip select is high, and that the host does not drive lanes while the target returns read or status data. The stimulus holds each host clock phase for eight block cycles, switches the route only between transactions, and drives zeros on the lanes during read phases. Under these rules the wrap and release checks hold, as do the register and unmapped read-back checks and the checks on the external port while the bus is parked.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

   localparam int ADDR_W = 24;
   localparam int LANES  = 4;

   localparam logic [7:0] OP_QREAD  = 8'hEB;
   localparam logic [7:0] OP_QPROG  = 8'h38;
   localparam logic [7:0] OP_RDSTAT = 8'h05;

   localparam logic [7:0] REG_PAGE = 8'hFF;

   typedef logic [ADDR_W-1:0] addr_t;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_READ,
      ST_WRITE,
      ST_STAT,
      ST_SKIP
   } eng_state_t;

endpackage

// File: rtl/qmt_sync.sv
module qmt_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("qmt_sync: STAGES must be 2..4");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/qmt_route.sv
module qmt_route
   import qmt_pkg::*;
(
   input  logic             route_int,
   input  logic             host_sck,
   input  logic             host_csn,
   input  logic [LANES-1:0] host_io_i,
   output logic [LANES-1:0] host_io_o,
   output logic [LANES-1:0] host_io_oe,
   output logic             host_irq,
   output logic             ext_sck,
   output logic             ext_csn,
   output logic [LANES-1:0] ext_io_o,
   output logic [LANES-1:0] ext_io_oe,
   input  logic [LANES-1:0] ext_io_i,
   input  logic [LANES-1:0] ext_io_drv,
   input  logic             ext_irq,
   output logic             tgt_sck,
   output logic             tgt_csn,
   output logic [LANES-1:0] tgt_io_i,
   input  logic [LANES-1:0] tgt_io_o,
   input  logic [LANES-1:0] tgt_io_oe
);

   // internal side sees an idle bus unless it owns the route
   assign tgt_sck    = host_sck & route_int;
   assign tgt_csn    = host_csn | ~route_int;
   assign tgt_io_i   = host_io_i & {LANES{route_int}};

   // external side is parked while the route is internal
   assign ext_sck    = host_sck & ~route_int;
   assign ext_csn    = host_csn | route_int;
   assign ext_io_o   = route_int ? '0 : host_io_i;
   assign ext_io_oe  = route_int ? '0 : ~ext_io_drv;

   assign host_io_o  = route_int ? tgt_io_o  : ext_io_i;
   assign host_io_oe = route_int ? tgt_io_oe : ext_io_drv;

   // interrupt masked while the bus is taken
   assign host_irq   = ext_irq & ~route_int;

endmodule

// File: rtl/qmt_store.sv
module qmt_store
   import qmt_pkg::*;
#(
   parameter int RAM_DEPTH = 1024,
   parameter int NUM_REGS  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  addr_t      rd_addr,
   output logic [7:0] rd_data,
   input  logic       we,
   input  addr_t      wr_addr,
   input  logic [7:0] wr_data
);

   localparam int          RAM_AW  = $clog2(RAM_DEPTH);
   localparam int          REG_AW  = $clog2(NUM_REGS);
   localparam addr_t       RAM_END = addr_t'(RAM_DEPTH - 1);
   localparam logic [15:0] REG_CNT = 16'(NUM_REGS);

   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0 || NUM_REGS > 256) begin : g_bad_regs
      $error("qmt_store: NUM_REGS must be a power of two in 2..256");
   end

   logic rd_ram, rd_reg, wr_ram, wr_reg;

   assign rd_ram = (rd_addr <= RAM_END);
   assign rd_reg = (rd_addr[23:16] == REG_PAGE) && (rd_addr[15:0] < REG_CNT);
   assign wr_ram = (wr_addr <= RAM_END);
   assign wr_reg = (wr_addr[23:16] == REG_PAGE) && (wr_addr[15:0] < REG_CNT);

   logic [7:0] mem  [RAM_DEPTH];
   logic [7:0] regs [NUM_REGS];

   always_ff @(posedge clk) begin
      if (we && wr_ram) mem[wr_addr[RAM_AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
      end else if (we && wr_reg) begin
         regs[wr_addr[REG_AW-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= 8'h00;
      else if (rd_ram) rd_data <= mem[rd_addr[RAM_AW-1:0]];
      else if (rd_reg) rd_data <= regs[rd_addr[REG_AW-1:0]];
      else             rd_data <= 8'h00;
   end

   // unmapped addresses read as zero
   p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_ram && !rd_reg) |=> (rd_data == 8'h00));

endmodule

// File: rtl/qmt_engine.sv
module qmt_engine
   import qmt_pkg::*;
#(
   parameter int         RAM_DEPTH   = 1024,
   parameter int         DUMMY_CLKS  = 6,
   parameter logic [7:0] STATUS_BYTE = 8'h54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             csn_s,
   input  logic [LANES-1:0] io_s,
   output addr_t            addr,
   input  logic [7:0]       rd_data,
   output logic             we,
   output addr_t            wr_addr,
   output logic [7:0]       wr_data,
   output logic [LANES-1:0] io_o,
   output logic [LANES-1:0] io_oe
);

   localparam addr_t      RAM_END    = addr_t'(RAM_DEPTH - 1);
   localparam logic [7:0] DUMMY_LAST = 8'(DUMMY_CLKS - 1);
   localparam logic [7:0] CMD_LAST   = 8'd7;
   localparam logic [7:0] ADDR_LAST  = 8'(ADDR_W / LANES - 1);

   if (DUMMY_CLKS < 1 || DUMMY_CLKS > 255) begin : g_bad_dummy
      $error("qmt_engine: DUMMY_CLKS must be 1..255");
   end

   function automatic addr_t adv(input addr_t a);
      if (a == RAM_END) return '0;
      return a + addr_t'(1);
   endfunction

   eng_state_t       state;
   logic [7:0]       cnt;
   logic [6:0]       sh;
   logic             is_rd;
   logic             hi;
   logic [LANES-1:0] wnib;
   logic [2:0]       bit_idx;
   logic             sck_d;
   logic             rise, fall;

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_CMD;
         cnt     <= '0;
         sh      <= '0;
         is_rd   <= 1'b0;
         hi      <= 1'b1;
         wnib    <= '0;
         bit_idx <= 3'd7;
         sck_d   <= 1'b0;
         addr    <= '0;
         we      <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         io_o    <= '0;
         io_oe   <= '0;
      end else begin
         sck_d <= sck_s;
         we    <= 1'b0;
         if (csn_s) begin
            state   <= ST_CMD;
            cnt     <= '0;
            hi      <= 1'b1;
            bit_idx <= 3'd7;
            io_oe   <= '0;
         end else begin
            unique case (state)
               ST_CMD: if (rise) begin
                  sh  <= {sh[5:0], io_s[0]};
                  cnt <= cnt + 8'd1;
                  if (cnt == CMD_LAST) begin
                     cnt <= '0;
                     case ({sh, io_s[0]})
                        OP_QREAD:  begin state <= ST_ADDR; is_rd <= 1'b1; end
                        OP_QPROG:  begin state <= ST_ADDR; is_rd <= 1'b0; end
                        OP_RDSTAT: state <= ST_STAT;
                        default:   state <= ST_SKIP;
                     endcase
                  end
               end
               ST_ADDR: if (rise) begin
                  addr <= {addr[ADDR_W-LANES-1:0], io_s};
                  cnt  <= cnt + 8'd1;
                  if (cnt == ADDR_LAST) begin
                     cnt   <= '0;
                     hi    <= 1'b1;
                     state <= is_rd ? ST_DUMMY : ST_WRITE;
                  end
               end
               ST_DUMMY: if (rise) begin
                  cnt <= cnt + 8'd1;
                  if (cnt == DUMMY_LAST) begin
                     cnt   <= '0;
                     state <= ST_READ;
                  end
               end
               ST_READ: if (fall) begin
                  io_o  <= hi ? rd_data[7:4] : rd_data[3:0];
                  io_oe <= '1;
                  if (!hi) addr <= adv(addr);
                  hi <= ~hi;
               end
               ST_WRITE: if (rise) begin
                  if (hi) begin
                     wnib <= io_s;
                     hi   <= 1'b0;
                  end else begin
                     we      <= 1'b1;
                     wr_addr <= addr;
                     wr_data <= {wnib, io_s};
                     addr    <= adv(addr);
                     hi      <= 1'b1;
                  end
               end
               ST_STAT: if (fall) begin
                  io_o    <= {2'b00, STATUS_BYTE[bit_idx], 1'b0};
                  io_oe   <= 4'b0010;
                  bit_idx <= bit_idx - 3'd1;
               end
               ST_SKIP: ;
               default: state <= ST_SKIP;
            endcase
         end
      end
   end

   // lanes released once chip select is seen high
   p_release_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> (io_oe == '0));

   // ignored opcodes neither write nor drive
   p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!we && io_oe == '0));

   // a write at the last RAM byte wraps the pointer to zero
   p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_addr == RAM_END) |-> (addr == '0));

   // status uses lane 1 only
   p_stat_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STAT) |-> (io_oe == 4'b0000 || io_oe == 4'b0010));

   // write-in-progress bit is driven as zero
   p_stat_wip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STAT && io_oe[1] && bit_idx == 3'd7) |-> !io_o[1]);

endmodule

// File: rtl/qspi_memtarget.sv
module qspi_memtarget
   import qmt_pkg::*;
#(
   parameter int         RAM_DEPTH   = 1024,
   parameter int         NUM_REGS    = 4,
   parameter int         DUMMY_CLKS  = 6,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] STATUS_ID   = 7'h2A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       route_int,
   input  logic       host_sck,
   input  logic       host_csn,
   input  logic [3:0] host_io_i,
   output logic [3:0] host_io_o,
   output logic [3:0] host_io_oe,
   output logic       host_irq,
   output logic       ext_sck,
   output logic       ext_csn,
   output logic [3:0] ext_io_o,
   output logic [3:0] ext_io_oe,
   input  logic [3:0] ext_io_i,
   input  logic [3:0] ext_io_drv,
   input  logic       ext_irq
);

   localparam logic [7:0] STATUS_BYTE = {STATUS_ID, 1'b0};
   localparam int         BUS_W       = LANES + 2;

   if (RAM_DEPTH < 512 || RAM_DEPTH > 65536 || (RAM_DEPTH & (RAM_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qspi_memtarget: RAM_DEPTH must be a power of two in 512..65536");
   end

   logic             tgt_sck, tgt_csn;
   logic [LANES-1:0] tgt_io_i, tgt_io_o, tgt_io_oe;
   logic [BUS_W-1:0] bus_s;
   addr_t            rd_addr, wr_addr;
   logic [7:0]       rd_data, wr_data;
   logic             we;

   qmt_route u_route (
      .route_int (route_int),
      .host_sck  (host_sck),
      .host_csn  (host_csn),
      .host_io_i (host_io_i),
      .host_io_o (host_io_o),
      .host_io_oe(host_io_oe),
      .host_irq  (host_irq),
      .ext_sck   (ext_sck),
      .ext_csn   (ext_csn),
      .ext_io_o  (ext_io_o),
      .ext_io_oe (ext_io_oe),
      .ext_io_i  (ext_io_i),
      .ext_io_drv(ext_io_drv),
      .ext_irq   (ext_irq),
      .tgt_sck   (tgt_sck),
      .tgt_csn   (tgt_csn),
      .tgt_io_i  (tgt_io_i),
      .tgt_io_o  (tgt_io_o),
      .tgt_io_oe (tgt_io_oe)
   );

   qmt_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL({1'b0, 1'b1, {LANES{1'b0}}})
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({tgt_sck, tgt_csn, tgt_io_i}),
      .q    (bus_s)
   );

   qmt_engine #(
      .RAM_DEPTH  (RAM_DEPTH),
      .DUMMY_CLKS (DUMMY_CLKS),
      .STATUS_BYTE(STATUS_BYTE)
   ) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_s  (bus_s[BUS_W-1]),
      .csn_s  (bus_s[BUS_W-2]),
      .io_s   (bus_s[LANES-1:0]),
      .addr   (rd_addr),
      .rd_data(rd_data),
      .we     (we),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .io_o   (tgt_io_o),
      .io_oe  (tgt_io_oe)
   );

   qmt_store #(
      .RAM_DEPTH(RAM_DEPTH),
      .NUM_REGS (NUM_REGS)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .we     (we),
      .wr_addr(wr_addr),
      .wr_data(wr_data)
   );

   // external interrupt hidden while the bus is internal
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      route_int |-> !host_irq);

   // external device parked while the bus is internal
   p_ext_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      route_int |-> (ext_csn && !ext_sck && ext_io_oe == '0));

   // pass-through select follows the host
   p_pass_csn_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !route_int |-> (ext_csn == host_csn && host_io_oe == ext_io_drv));

endmodule

// File: tb/qspi_memtarget_tb_top.sv
module qspi_memtarget_tb_top;

   localparam time CLK_P = 4ns;
   localparam time HALF  = 32ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       route_int;
   logic       host_sck, host_csn;
   logic [3:0] host_io_i, host_io_o, host_io_oe;
   logic       host_irq;
   logic       ext_sck, ext_csn;
   logic [3:0] ext_io_o, ext_io_oe, ext_io_i, ext_io_drv;
   logic       ext_irq;

   always #(CLK_P/2) clk = ~clk;

   qspi_memtarget dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .route_int (route_int),
      .host_sck  (host_sck),
      .host_csn  (host_csn),
      .host_io_i (host_io_i),
      .host_io_o (host_io_o),
      .host_io_oe(host_io_oe),
      .host_irq  (host_irq),
      .ext_sck   (ext_sck),
      .ext_csn   (ext_csn),
      .ext_io_o  (ext_io_o),
      .ext_io_oe (ext_io_oe),
      .ext_io_i  (ext_io_i),
      .ext_io_drv(ext_io_drv),
      .ext_irq   (ext_irq)
   );

   int         n_chk  = 0;
   int         n_fail = 0;
   logic [7:0] wbuf [512];
   logic [7:0] rbuf [512];

   // {write addr, write data, read addr, expected}
   localparam logic [63:0] VEC [6] = '{
      64'h000010A5_000010A5,   // R1 R2 RAM byte
      64'hFF00013C_FF00013C,   // R4 register 1
      64'hFF000777_FF000700,   // R4 window gap reads zero
      64'h00080099_00080000,   // R4 above RAM reads zero
      64'h0003FF5A_0003FF5A,   // R5 last RAM byte
      64'hFF0003C3_FF0003C3    // R4 register 3
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clk_out(input logic [3:0] v);
      host_io_i = v;
      #HALF;
      host_sck = 1'b1;
      #HALF;
      host_sck = 1'b0;
   endtask

   task automatic read_nib(output logic [3:0] v);
      host_io_i = 4'h0;
      #HALF;
      v = host_io_o;
      host_sck = 1'b1;
      #HALF;
      host_sck = 1'b0;
   endtask

   task automatic begin_tx();
      host_csn = 1'b0;
      #HALF;
   endtask

   task automatic end_tx();
      host_io_i = 4'h0;
      #HALF;
      host_csn = 1'b1;
      #(4*HALF);
   endtask

   task automatic send_cmd(input logic [7:0] op);
      for (int i = 7; i >= 0; i--) clk_out({3'b000, op[i]});
   endtask

   task automatic send_addr(input logic [23:0] a);
      for (int i = 5; i >= 0; i--) clk_out(a[i*4 +: 4]);
   endtask

   task automatic qwrite(input logic [23:0] a, input int n);
      begin_tx();
      send_cmd(8'h38);
      send_addr(a);
      for (int i = 0; i < n; i++) begin
         clk_out(wbuf[i][7:4]);
         clk_out(wbuf[i][3:0]);
      end
      end_tx();
   endtask

   task automatic qread(input logic [23:0] a, input int n);
      logic [3:0] h, l;
      begin_tx();
      send_cmd(8'hEB);
      send_addr(a);
      for (int i = 0; i < 6; i++) clk_out(4'h0);
      for (int i = 0; i < n; i++) begin
         read_nib(h);
         read_nib(l);
         rbuf[i] = {h, l};
      end
      end_tx();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int         bad;
      logic [3:0] v;
      logic [7:0] sbyte;
      rst_n      = 1'b0;
      route_int  = 1'b1;
      host_sck   = 1'b0;
      host_csn   = 1'b1;
      host_io_i  = 4'h0;
      ext_io_i   = 4'h0;
      ext_io_drv = 4'h0;
      ext_irq    = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11 reset state
      chk("R11 lanes idle", 32'(host_io_oe), 32'h0);
      qread(24'hFF0000, 1);
      chk("R11 register reset", 32'(rbuf[0]), 32'h00);

      // vector table: single-byte write then read
      for (int k = 0; k < 6; k++) begin
         wbuf[0] = VEC[k][39:32];
         qwrite(VEC[k][63:40], 1);
         qread(VEC[k][31:8], 1);
         chk("R1 R2 R4 vector", 32'(rbuf[0]), 32'(VEC[k][7:0]));
      end

      // R10 full 512-byte block
      for (int i = 0; i < 512; i++) wbuf[i] = 8'((i * 7 + 3) & 255);
      qwrite(24'h000200, 512);
      qread(24'h000200, 512);
      bad = 0;
      for (int i = 0; i < 512; i++) if (rbuf[i] !== wbuf[i]) bad++;
      chk("R10 block mismatches", 32'(bad), 32'h0);

      // R5 wrap across end of RAM
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      qwrite(24'h0003FE, 3);
      qread(24'h0003FE, 3);
      chk("R5 wrap byte 0", 32'(rbuf[0]), 32'h11);
      chk("R5 wrap byte 1", 32'(rbuf[1]), 32'h22);
      chk("R5 wrap byte 2 at 0", 32'(rbuf[2]), 32'h33);
      qread(24'h000000, 1);
      chk("R5 write landed at 0", 32'(rbuf[0]), 32'h33);

      // R3 erase opcodes ignored
      begin_tx();
      send_cmd(8'h20);
      send_addr(24'h000000);
      clk_out(4'hF); clk_out(4'hF);
      chk("R3 erase undriven", 32'(host_io_oe), 32'h0);
      end_tx();
      begin_tx();
      send_cmd(8'hD8);
      send_addr(24'h000000);
      clk_out(4'hF); clk_out(4'hF);
      end_tx();
      begin_tx();
      send_cmd(8'hC7);
      clk_out(4'hF); clk_out(4'hF);
      chk("R3 chip erase undriven", 32'(host_io_oe), 32'h0);
      end_tx();
      qread(24'h000000, 1);
      chk("R3 data kept", 32'(rbuf[0]), 32'h33);

      // R6 status byte on lane 1
      begin_tx();
      send_cmd(8'h05);
      for (int r = 0; r < 2; r++) begin
         sbyte = 8'h00;
         for (int i = 0; i < 8; i++) begin
            read_nib(v);
            sbyte = {sbyte[6:0], v[1]};
         end
         chk("R6 status value", 32'(sbyte), 32'h54);
      end
      chk("R6 lane 1 only", 32'(host_io_oe), 32'h2);
      end_tx();

      // R7 abort mid-byte during a page program
      wbuf[0] = 8'h00; wbuf[1] = 8'h66;
      qwrite(24'h000100, 2);
      begin_tx();
      send_cmd(8'h38);
      send_addr(24'h000100);
      clk_out(4'hA); clk_out(4'hA); clk_out(4'hB);
      end_tx();
      qread(24'h000100, 2);
      chk("R7 completed byte kept", 32'(rbuf[0]), 32'hAA);
      chk("R7 partial byte dropped", 32'(rbuf[1]), 32'h66);

      // R7 abort during a read releases lanes and next select decodes
      begin_tx();
      send_cmd(8'hEB);
      send_addr(24'h000100);
      for (int i = 0; i < 6; i++) clk_out(4'h0);
      read_nib(v);
      end_tx();
      chk("R7 lanes released", 32'(host_io_oe), 32'h0);
      begin_tx();
      send_cmd(8'h05);
      sbyte = 8'h00;
      for (int i = 0; i < 8; i++) begin
         read_nib(v);
         sbyte = {sbyte[6:0], v[1]};
      end
      end_tx();
      chk("R7 fresh decode after abort", 32'(sbyte), 32'h54);

      // R9 internal route masks irq and parks the external device
      ext_irq = 1'b1;
      #HALF;
      chk("R9 irq masked", 32'(host_irq), 32'h0);
      host_csn = 1'b0;
      host_sck = 1'b1;
      #HALF;
      chk("R9 ext csn parked", 32'(ext_csn), 32'h1);
      chk("R9 ext sck parked", 32'(ext_sck), 32'h0);
      host_sck = 1'b0;
      host_csn = 1'b1;
      #(4*HALF);

      // R8 pass-through
      route_int = 1'b0;
      #HALF;
      chk("R8 irq passes", 32'(host_irq), 32'h1);
      host_csn   = 1'b0;
      host_sck   = 1'b1;
      host_io_i  = 4'h9;
      ext_io_i   = 4'h6;
      ext_io_drv = 4'hF;
      #HALF;
      chk("R8 ext csn follows", 32'(ext_csn), 32'h0);
      chk("R8 ext sck follows", 32'(ext_sck), 32'h1);
      chk("R8 ext lanes follow", 32'(ext_io_o), 32'h9);
      chk("R8 return data", 32'(host_io_o), 32'h6);
      chk("R8 return enable", 32'(host_io_oe), 32'hF);
      chk("R8 forward enable", 32'(ext_io_oe), 32'h0);
      host_sck   = 1'b0;
      host_csn   = 1'b1;
      ext_io_drv = 4'h0;
      host_io_i  = 4'h0;
      #(4*HALF);
      wbuf[0] = 8'hEE;
      qwrite(24'h000000, 1);
      route_int = 1'b1;
      ext_irq   = 1'b0;
      #(4*HALF);
      qread(24'h000000, 1);
      chk("R8 internal target ignored traffic", 32'(rbuf[0]), 32'h33);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule